// File: doc/BRIEF.md
# Sleep-Mode Clock-Domain Gate Controller

This block decides which clock domains of a small microcontroller receive a clock enable. It gates five domains: the processor core, the peripheral I/O fabric, the analog-to-digital converter, the asynchronous timer and the main oscillator. While the block is running, every domain is enabled. When software has armed sleep and issues a sleep command strobe, the block latches a 3-bit mode code. From the next cycle it keeps only the subset of domains that belongs to that mode.

The block leaves a sleep mode on a wake event. The external interrupt always counts as a wake event. A peripheral, converter or timer interrupt counts only if its domain is still clocked in the current mode. Reset also ends any sleep. If the mode had stopped the main oscillator, the core, I/O and converter stay gated for a programmable number of warm-up cycles after the wake, so that the oscillator can settle. The interrupt inputs are taken as already masked by their enable bits.

Top module: `slp_clk_ctrl`

## Requirements
- R1: One cycle after a clock edge that samples `rst` high, all five enables are 1 and `sleeping` is 0.
- R2: A sleep command sampled while `slp_en` is 0 has no effect, and all enables stay 1.
- R3: A sleep command sampled with `slp_en` at 1 while running makes `sleeping` 1 and `en_cpu` 0 on the next cycle. The mode code is latched at that edge, so later changes of `mode_sel` have no effect until the device wakes.
- R4: Mode code 000 (idle) gates only the core, so io, adc, timer and oscillator stay enabled. Reserved codes 100 and 101 act exactly as 000.
- R5: Mode code 001 (converter quiet) gates the core and the I/O domain, and keeps the converter, the timer and the oscillator enabled.
- R6: Mode code 010 (deep power-down) gates all five domains.
- R7: Mode code 011 (timer-retaining power-down) keeps only the asynchronous timer enabled.
- R8: Mode code 110 (standby) keeps only the oscillator enabled. Mode code 111 (extended standby) keeps the oscillator and the timer enabled.
- R9: While asleep, `ext_irq` always wakes the block. Any bit of `io_irq`, `adc_irq` or `atmr_irq` wakes it only if the enable of its own domain is 1 in the latched mode; otherwise it is ignored and the block stays asleep.
- R10: A wake from a mode that keeps the oscillator running restores all enables and clears `sleeping` on the next cycle.
- R11: A wake from mode 010 or 011 with `warm_cycles` = N > 0 gives N cycles in which only the oscillator and the timer are enabled and `sleeping` stays 1; the block runs from the cycle after those N. With N = 0 it runs on the next cycle.
- R12: Reset asleep or during warm-up returns the block to running (all enables 1, `sleeping` 0) on the next cycle.
- R13: A sleep command that arrives while asleep or during warm-up is ignored, and the latched mode is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slp_en | input | 1 | Arms the sleep command |
| mode_sel | input | 3 | Sleep mode code |
| slp_cmd | input | 1 | Sleep command strobe |
| ext_irq | input | 1 | External interrupt, a wake source in every mode |
| io_irq | input | N_IO | Masked interrupt requests from the I/O domain |
| adc_irq | input | 1 | Masked converter interrupt request |
| atmr_irq | input | 1 | Masked asynchronous timer interrupt request |
| warm_cycles | input | CNT_W | Oscillator warm-up length in cycles |
| en_cpu | output | 1 | Core clock enable |
| en_io | output | 1 | Peripheral I/O clock enable |
| en_adc | output | 1 | Converter clock enable |
| en_atmr | output | 1 | Asynchronous timer clock enable |
| en_osc | output | 1 | Main oscillator enable |
| sleeping | output | 1 | High while asleep or warming up |

## Verification
The assertions assume that every input is synchronous to `clk`, and that the interrupt lines already carry their enable masking. They also assume that `warm_cycles` is valid on the cycle of a wake, because the block loads it only then. The bench changes all inputs one time unit after the rising edge, so each value is settled well before the next sampling edge. Its random phase draws the interrupt, sleep-command and reset lines with low probabilities, so that the sleep modes are entered and left many times. It also changes `mode_sel` and `warm_cycles` freely, including during sleep and warm-up, where the block must ignore them.

// File: rtl/slp_pkg.sv
`timescale 1ns/1ps
package slp_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        M_IDLE  = 3'd0,
        M_QUIET = 3'd1,
        M_PDOWN = 3'd2,
        M_PSAVE = 3'd3,
        M_STBY  = 3'd6,
        M_XSTBY = 3'd7
    } slp_mode_e;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_SLEEP,
        ST_WARM
    } ctl_state_e;

    typedef struct packed {
        logic cpu;
        logic io;
        logic adc;
        logic atmr;
        logic osc;
    } dom_en_t;

    // Reserved codes fold onto idle.
    function automatic slp_mode_e canon_mode(logic [MODE_W-1:0] code);
        slp_mode_e m;
        case (code)
            3'd1:    m = M_QUIET;
            3'd2:    m = M_PDOWN;
            3'd3:    m = M_PSAVE;
            3'd6:    m = M_STBY;
            3'd7:    m = M_XSTBY;
            default: m = M_IDLE;
        endcase
        return m;
    endfunction

    function automatic dom_en_t all_on();
        dom_en_t d;
        d = '1;
        return d;
    endfunction

    function automatic dom_en_t warm_domains();
        dom_en_t d;
        d      = '0;
        d.atmr = 1'b1;
        d.osc  = 1'b1;
        return d;
    endfunction

    function automatic dom_en_t mode_domains(slp_mode_e m);
        dom_en_t d;
        d = '0;
        case (m)
            M_IDLE: begin
                d.io = 1'b1; d.adc = 1'b1; d.atmr = 1'b1; d.osc = 1'b1;
            end
            M_QUIET: begin
                d.adc = 1'b1; d.atmr = 1'b1; d.osc = 1'b1;
            end
            M_PSAVE: d.atmr = 1'b1;
            M_STBY:  d.osc  = 1'b1;
            M_XSTBY: begin
                d.atmr = 1'b1; d.osc = 1'b1;
            end
            default: d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/slp_mode_dec.sv
`timescale 1ns/1ps
module slp_mode_dec
    import slp_pkg::*;
(
    input  logic [MODE_W-1:0] code_i,
    output slp_mode_e         mode_o
);
    always_comb mode_o = canon_mode(code_i);
endmodule

// File: rtl/slp_wake_qual.sv
`timescale 1ns/1ps
module slp_wake_qual
    import slp_pkg::*;
#(
    parameter int N_IO = 4
) (
    input  slp_mode_e       mode_i,
    input  logic            ext_irq_i,
    input  logic [N_IO-1:0] io_irq_i,
    input  logic            adc_irq_i,
    input  logic            atmr_irq_i,
    output logic            wake_o,
    output logic            cold_o
);
    dom_en_t run;
    logic    io_any;

    always_comb begin
        run    = mode_domains(mode_i);
        io_any = |io_irq_i;
        // A domain's request counts only if that domain is still clocked.
        wake_o = ext_irq_i
               | (io_any     & run.io)
               | (adc_irq_i  & run.adc)
               | (atmr_irq_i & run.atmr);
        cold_o = ~run.osc;
    end
endmodule

// File: rtl/slp_warm_tmr.sv
`timescale 1ns/1ps
module slp_warm_tmr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - LAST;
        end
    end

    assign expire_o = (cnt_q == LAST);
endmodule

// File: rtl/slp_clk_ctrl.sv
`timescale 1ns/1ps
module slp_clk_ctrl
    import slp_pkg::*;
#(
    parameter int N_IO  = 4,
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slp_en,
    input  logic [2:0]        mode_sel,
    input  logic              slp_cmd,
    input  logic              ext_irq,
    input  logic [N_IO-1:0]   io_irq,
    input  logic              adc_irq,
    input  logic              atmr_irq,
    input  logic [CNT_W-1:0]  warm_cycles,
    output logic              en_cpu,
    output logic              en_io,
    output logic              en_adc,
    output logic              en_atmr,
    output logic              en_osc,
    output logic              sleeping
);
    ctl_state_e state_q, state_d;
    slp_mode_e  mode_q, mode_new;
    logic       wake, cold, warm_needed, warm_load, warm_done, enter;
    dom_en_t    dom;

    slp_mode_dec u_dec (
        .code_i (mode_sel),
        .mode_o (mode_new)
    );

    slp_wake_qual #(.N_IO(N_IO)) u_wake (
        .mode_i     (mode_q),
        .ext_irq_i  (ext_irq),
        .io_irq_i   (io_irq),
        .adc_irq_i  (adc_irq),
        .atmr_irq_i (atmr_irq),
        .wake_o     (wake),
        .cold_o     (cold)
    );

    assign warm_needed = cold && (warm_cycles != '0);
    assign warm_load   = (state_q == ST_SLEEP) && wake && warm_needed;
    assign enter       = (state_q == ST_RUN) && slp_cmd && slp_en;

    slp_warm_tmr #(.CNT_W(CNT_W)) u_tmr (
        .clk        (clk),
        .rst        (rst),
        .load_i     (warm_load),
        .load_val_i (warm_cycles),
        .expire_o   (warm_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (enter) state_d = ST_SLEEP;
            ST_SLEEP: if (wake)  state_d = warm_needed ? ST_WARM : ST_RUN;
            ST_WARM:  if (warm_done) state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            mode_q  <= M_IDLE;
        end else begin
            state_q <= state_d;
            if (enter) mode_q <= mode_new;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_SLEEP: dom = mode_domains(mode_q);
            ST_WARM:  dom = warm_domains();
            default:  dom = all_on();
        endcase
    end

    assign en_cpu   = dom.cpu;
    assign en_io    = dom.io;
    assign en_adc   = dom.adc;
    assign en_atmr  = dom.atmr;
    assign en_osc   = dom.osc;
    assign sleeping = (state_q != ST_RUN);
endmodule

// File: rtl/slp_clk_ctrl_chk.sv
`timescale 1ns/1ps
module slp_clk_ctrl_chk #(
    parameter int N_IO  = 4,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             slp_en,
    input logic             slp_cmd,
    input logic             ext_irq,
    input logic [N_IO-1:0]  io_irq,
    input logic [CNT_W-1:0] warm_cycles,
    input logic             en_cpu,
    input logic             en_io,
    input logic             en_adc,
    input logic             en_atmr,
    input logic             en_osc,
    input logic             sleeping
);
    assert_reset_all_on_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (en_cpu && en_io && en_adc && en_atmr && en_osc && !sleeping));

    assert_unarmed_cmd_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (!sleeping && slp_cmd && !slp_en) |=> !sleeping);

    assert_armed_cmd_sleeps_R3: assert property (@(posedge clk) disable iff (rst)
        (!sleeping && slp_cmd && slp_en) |=> (sleeping && !en_cpu));

    assert_no_osc_no_core_R6: assert property (@(posedge clk) disable iff (rst)
        !en_osc |-> (!en_cpu && !en_io && !en_adc));

    assert_core_implies_running_R10: assert property (@(posedge clk) disable iff (rst)
        en_cpu |-> (en_io && en_adc && en_atmr && en_osc && !sleeping));

    assert_io_irq_wakes_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (sleeping && en_io && (|io_irq)) |=> !sleeping);

    assert_cold_wake_holds_core_R11: assert property (@(posedge clk) disable iff (rst)
        (sleeping && !en_osc && ext_irq && warm_cycles != '0) |=> (sleeping && en_osc && !en_cpu));
endmodule

bind slp_clk_ctrl slp_clk_ctrl_chk #(.N_IO(N_IO), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .slp_en      (slp_en),
    .slp_cmd     (slp_cmd),
    .ext_irq     (ext_irq),
    .io_irq      (io_irq),
    .warm_cycles (warm_cycles),
    .en_cpu      (en_cpu),
    .en_io       (en_io),
    .en_adc      (en_adc),
    .en_atmr     (en_atmr),
    .en_osc      (en_osc),
    .sleeping    (sleeping)
);

// File: tb/slp_clk_ctrl_test.sv
`timescale 1ns/1ps
module slp_clk_ctrl_test;
    localparam int N_IO  = 4;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst, slp_en, slp_cmd, ext_irq, adc_irq, atmr_irq;
    logic [2:0]       mode_sel;
    logic [N_IO-1:0]  io_irq;
    logic [CNT_W-1:0] warm_cycles;
    logic             en_cpu, en_io, en_adc, en_atmr, en_osc, sleeping;

    int n_vec = 0;
    int n_bad = 0;

    // Model state: 0 running, 1 asleep, 2 warm-up.
    int         ms = 0;
    logic [2:0] mm = 3'd0;
    int         mc = 0;

    always #2.5 clk = ~clk;

    slp_clk_ctrl #(.N_IO(N_IO), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .slp_en(slp_en), .mode_sel(mode_sel),
        .slp_cmd(slp_cmd), .ext_irq(ext_irq), .io_irq(io_irq),
        .adc_irq(adc_irq), .atmr_irq(atmr_irq), .warm_cycles(warm_cycles),
        .en_cpu(en_cpu), .en_io(en_io), .en_adc(en_adc), .en_atmr(en_atmr),
        .en_osc(en_osc), .sleeping(sleeping)
    );

    // Bit order {cpu, io, adc, atmr, osc}.
    function automatic logic [4:0] want_dom(logic [2:0] code);
        case (code)
            3'd1:    return 5'b00111;
            3'd2:    return 5'b00000;
            3'd3:    return 5'b00010;
            3'd6:    return 5'b00001;
            3'd7:    return 5'b00011;
            default: return 5'b01111;
        endcase
    endfunction

    function automatic logic [5:0] want_out();
        if (ms == 0) return 6'b111110;
        if (ms == 2) return 6'b000111;
        return {want_dom(mm), 1'b1};
    endfunction

    task automatic model_step();
        logic [4:0] d;
        logic       wk;
        d  = want_dom(mm);
        wk = ext_irq | ((|io_irq) & d[3]) | (adc_irq & d[2]) | (atmr_irq & d[1]);
        if (rst) begin
            ms = 0; mc = 0;
        end else begin
            case (ms)
                0: if (slp_cmd && slp_en) begin ms = 1; mm = mode_sel; end
                1: if (wk) begin
                       if (!d[0] && warm_cycles != 0) begin ms = 2; mc = int'(warm_cycles); end
                       else ms = 0;
                   end
                default: if (mc == 1) ms = 0; else mc = mc - 1;
            endcase
        end
    endtask

    task automatic cycle(input string req);
        logic [5:0] act, exp_v;
        @(posedge clk);
        model_step();
        #1;
        act   = {en_cpu, en_io, en_adc, en_atmr, en_osc, sleeping};
        exp_v = want_out();
        n_vec++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b (cpu io adc atmr osc sleeping)", req, act, exp_v);
        end
    endtask

    task automatic quiet();
        slp_cmd = 0; ext_irq = 0; io_irq = '0; adc_irq = 0; atmr_irq = 0; rst = 0;
    endtask

    task automatic go_sleep(input logic [2:0] code, input string req);
        mode_sel = code; slp_en = 1; slp_cmd = 1;
        cycle(req);
        slp_cmd = 0;
    endtask

    function automatic string mode_req(logic [2:0] code);
        case (code)
            3'd1: return "R5";
            3'd2: return "R6";
            3'd3: return "R7";
            3'd6, 3'd7: return "R8";
            default: return "R4";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h1F2E3D4C);
        quiet(); slp_en = 0; mode_sel = 0; warm_cycles = 8'd2;
        rst = 1;
        cycle("R1"); cycle("R1");
        rst = 0;
        cycle("R1");

        // R2: unarmed command
        slp_en = 0; slp_cmd = 1; cycle("R2");
        slp_cmd = 0; cycle("R2");

        // R4..R8 each code, R3 mode change ignored, R10/R11 wake
        for (int c = 0; c < 8; c++) begin
            go_sleep(3'(c), mode_req(3'(c)));
            mode_sel = ~3'(c);
            cycle("R3");
            warm_cycles = 8'd2; ext_irq = 1;
            cycle((c == 2 || c == 3) ? "R11" : "R10");
            ext_irq = 0;
            repeat (3) cycle("R11");
        end

        // R9: ignored sources in power-down
        go_sleep(3'd2, "R6");
        io_irq = '1; adc_irq = 1; atmr_irq = 1;
        repeat (3) cycle("R9");
        quiet(); ext_irq = 1; warm_cycles = 8'd1; cycle("R9");
        ext_irq = 0; repeat (2) cycle("R11");

        // R9: quiet mode ignores io, wakes on adc
        go_sleep(3'd1, "R5");
        io_irq = 4'b0100; repeat (2) cycle("R9");
        adc_irq = 1; cycle("R9");
        quiet(); cycle("R9");

        // R9: timer wakes timer-retaining power-down, then warm-up
        go_sleep(3'd3, "R7");
        io_irq = '1; cycle("R9");
        atmr_irq = 1; warm_cycles = 8'd3; cycle("R9");
        quiet(); repeat (4) cycle("R11");

        // R11: zero warm-up, and a longer one
        warm_cycles = 8'd0;
        go_sleep(3'd2, "R6");
        ext_irq = 1; cycle("R11");
        ext_irq = 0; cycle("R11");
        warm_cycles = 8'd5;
        go_sleep(3'd2, "R6");
        ext_irq = 1; cycle("R11");
        ext_irq = 0; warm_cycles = 8'd1;
        repeat (6) cycle("R11");

        // R12: reset asleep and during warm-up
        go_sleep(3'd6, "R8");
        rst = 1; cycle("R12"); rst = 0; cycle("R12");
        warm_cycles = 8'd6;
        go_sleep(3'd2, "R6");
        ext_irq = 1; cycle("R11"); ext_irq = 0;
        cycle("R11");
        rst = 1; cycle("R12"); rst = 0; cycle("R12");

        // R13: command while asleep / warm-up
        go_sleep(3'd0, "R4");
        mode_sel = 3'd2; slp_cmd = 1; repeat (2) cycle("R13");
        slp_cmd = 0; io_irq = 4'b0001; cycle("R13");
        quiet(); warm_cycles = 8'd3;
        go_sleep(3'd3, "R7");
        ext_irq = 1; cycle("R13"); ext_irq = 0;
        mode_sel = 3'd0; slp_cmd = 1; repeat (3) cycle("R13");
        slp_cmd = 0; cycle("R13");

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            rst         = ($urandom % 200) == 0;
            slp_cmd     = ($urandom % 8) == 0;
            slp_en      = ($urandom % 4) != 0;
            mode_sel    = 3'($urandom);
            ext_irq     = ($urandom % 16) == 0;
            for (int b = 0; b < N_IO; b++) io_irq[b] = ($urandom % 8) == 0;
            adc_irq     = ($urandom % 10) == 0;
            atmr_irq    = ($urandom % 10) == 0;
            warm_cycles = CNT_W'($urandom % 7);
            cycle("R9");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule